// File: doc/BRIEF.md
# Dual-Address I2C Target Controller

This block is the target side of a two-wire serial bus. It watches the clock and data lines through a synchronizer. It picks out bus start, restart and stop conditions, and it compares each 7-bit address against two own addresses that software programs. When an address matches, the block acknowledges it. It then either receives bytes into its data register or sends the data register out, one bit at a time, starting with the most significant bit.

Software works through a small register file with five offsets:

- 0, control: bit 7 enables the block; bit 0 sets the acknowledge level the target drives after a received byte (0 pulls SDA low, which is ACK).
- 1, status.
- 2 and 3, the two own-address registers. Each holds its 7-bit address in bits [7:1].
- 4, data.

The status bits are:

| Bit | Meaning | How it clears |
|-----|---------|---------------|
| 7 | receive flag | write 1 |
| 6 | transmit flag | write 1 |
| 5 | first-address hit | read-only |
| 4 | second-address hit | read-only |
| 3 | direction (1 = read) | read-only |
| 2 | master acknowledge bit last seen (0 = ACK) | read-only |
| 1 | bus busy | read-only |
| 0 | repeated-start flag | write 1 |

Register reads are registered. `reg_rdata` shows the register selected by `reg_addr` one clock later. SDA is open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, control reads 0x00, status 0x00, first address 0xA0, second address 0x60 and data 0x00, and `sda_oe` is low.
- R2: Status bit 1 (busy) sets on a START and clears on the following STOP.
- R3: An address byte whose upper seven bits equal bits [7:1] of the first or the second address register is acknowledged (SDA pulled low in the ninth clock). The hit bit of the matching register (5 or 4) sets and the other hit bit reads 0.
- R4: On any other address the target does not acknowledge, sets neither hit bit, and ignores the data bytes that follow until the next START.
- R5: Status bit 3 equals the R/W bit (bit 0 of the address byte) of the last address phase.
- R6: In a write transfer, each received byte (MSB first) lands in the data register, sets status bit 7 and `rx_irq`, and is followed by an acknowledge bit whose level is control bit 0.
- R7: In a read transfer, the data register is sent MSB first. After the eighth bit, status bit 6 and `tx_irq` set. The master's acknowledge level is held in status bit 2. After an ACK, the current data register value is sent next.
- R8: A START while busy sets status bit 0 and starts a new address phase. A START from idle leaves bit 0 clear.
- R9: Writing 1 to status bits 7, 6 or 0 clears them. Writing 0 leaves them unchanged.
- R10: With control bit 7 clear, the block does not acknowledge, busy stays 0 and `sda_oe` stays low.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| rx_irq | output | 1 | Receive flag |
| tx_irq | output | 1 | Transmit flag |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A wrong state in the byte engine shows up on the bus within one bit time. A misplaced bit counter moves the acknowledge pulse, so the master reads a NACK where an ACK is due, or a shifted byte comes back in a read. A wrong address comparator shows up as a wrong ACK bit and a wrong hit bit for one of the 128 addresses swept. That result is seen before the STOP of the same transfer. Busy-flag or restart-flag errors appear in the status value read straight after the address phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKW, ST_ACKH, ST_RX, ST_TX, ST_TXACK, ST_IGN
  } eng_st_t;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_OWNA  = 3'd2;
  localparam logic [2:0] OFS_OWNB  = 3'd3;
  localparam logic [2:0] OFS_DATA  = 3'd4;

  localparam int SB_RXF  = 7;
  localparam int SB_TXF  = 6;
  localparam int SB_HITA = 5;
  localparam int SB_HITB = 4;
  localparam int SB_DIR  = 3;
  localparam int SB_RACK = 2;
  localparam int SB_BUSY = 1;
  localparam int SB_RSF  = 0;

  localparam int CB_EN   = 7;
  localparam int CB_ACKL = 0;
endpackage

// File: rtl/i2cs_front.sv
module i2cs_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] cur_v;
  logic [NLINES-1:0] old_v;

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= '1;
      else     stg <= {stg[STAGES-1:0], raw_v[g]};
    end
    assign cur_v[g] = stg[STAGES-1];
    assign old_v[g] = stg[STAGES];
  end

  logic scl_c, scl_o, sda_c, sda_o;
  assign scl_c = cur_v[0];
  assign scl_o = old_v[0];
  assign sda_c = cur_v[1];
  assign sda_o = old_v[1];

  assign sda_s    = sda_c;
  assign scl_rise = scl_c & ~scl_o;
  assign scl_fall = ~scl_c & scl_o;
  assign start_p  = scl_c & scl_o & sda_o & ~sda_c;
  assign stop_p   = scl_c & scl_o & ~sda_o & sda_c;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [DW-2:0] own_a,
  input  logic [DW-2:0] own_b,
  input  logic          ack_lvl,
  input  logic [DW-1:0] tx_byte,
  output logic          sda_oe,
  output logic          busy,
  output logic          dir,
  output logic          rx_ack,
  output logic          ev_addr,
  output logic          hit_a,
  output logic          hit_b,
  output logic          ev_rx,
  output logic [DW-1:0] rx_byte,
  output logic          ev_tx,
  output logic          ev_rs,
  output logic          ign
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  eng_st_t       st;
  logic [CW-1:0] cnt;
  logic [DW-2:0] sh;
  logic          ack_drv;
  logic          nxt_tx;
  logic          m_a, m_b;

  assign m_a = (sh == own_a);
  assign m_b = (sh == own_b);
  assign ign = (st == ST_IGN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; sda_oe <= 1'b0; busy <= 1'b0;
      dir <= 1'b0; rx_ack <= 1'b0; ack_drv <= 1'b0; nxt_tx <= 1'b0;
      ev_addr <= 1'b0; hit_a <= 1'b0; hit_b <= 1'b0; ev_rx <= 1'b0;
      rx_byte <= '0; ev_tx <= 1'b0; ev_rs <= 1'b0;
    end else if (!en) begin
      st <= ST_IDLE; sda_oe <= 1'b0; busy <= 1'b0; cnt <= '0;
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0; ev_rs <= 1'b0;
    end else begin
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0; ev_rs <= 1'b0;
      if (start_p) begin
        ev_rs  <= busy;
        busy   <= 1'b1;
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        busy   <= 1'b0;
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (scl_rise) begin
            sh  <= {sh[DW-3:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              dir     <= sda_s;
              ev_addr <= 1'b1;
              hit_a   <= m_a;
              hit_b   <= m_b;
              if (m_a || m_b) begin
                ack_drv <= 1'b1;
                nxt_tx  <= sda_s;
                st      <= ST_ACKW;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe <= ack_drv;
            st     <= ST_ACKH;
          end
          ST_ACKH: if (scl_fall) begin
            cnt <= '0;
            if (nxt_tx) begin
              sh     <= tx_byte[DW-2:0];
              sda_oe <= ~tx_byte[DW-1];
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
          ST_RX: if (scl_rise) begin
            sh  <= {sh[DW-3:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              rx_byte <= {sh, sda_s};
              ev_rx   <= 1'b1;
              ack_drv <= ~ack_lvl;
              nxt_tx  <= 1'b0;
              st      <= ST_ACKW;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              ev_tx  <= 1'b1;
              st     <= ST_TXACK;
            end else begin
              sda_oe <= ~sh[DW-2];
              sh     <= {sh[DW-3:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
          ST_TXACK: if (scl_rise) begin
            rx_ack <= sda_s;
            if (!sda_s) begin
              nxt_tx <= 1'b1;
              st     <= ST_ACKH;
            end else begin
              st <= ST_IGN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          AW     = 3,
  parameter logic [DW-1:0] OWNA_RST = 8'hA0,
  parameter logic [DW-1:0] OWNB_RST = 8'h60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_rx,
  input  logic [DW-1:0] rx_byte,
  input  logic          ev_tx,
  input  logic          ev_addr,
  input  logic          hit_a_i,
  input  logic          hit_b_i,
  input  logic          ev_rs,
  input  logic          dir,
  input  logic          rx_ack,
  input  logic          busy,
  output logic          en,
  output logic          ack_lvl,
  output logic [DW-2:0] own_a,
  output logic [DW-2:0] own_b,
  output logic [DW-1:0] data_q,
  output logic          rx_f,
  output logic          tx_f,
  output logic          hit_a,
  output logic          rs_f,
  output logic [DW-1:0] status
);
  logic hit_b;
  logic wr_ctrl, wr_stat, wr_owna, wr_ownb, wr_data;

  assign wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
  assign wr_owna = reg_wr && (reg_addr == AW'(OFS_OWNA));
  assign wr_ownb = reg_wr && (reg_addr == AW'(OFS_OWNB));
  assign wr_data = reg_wr && (reg_addr == AW'(OFS_DATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; ack_lvl <= 1'b0;
      own_a <= OWNA_RST[DW-1:1]; own_b <= OWNB_RST[DW-1:1];
      data_q <= '0; rx_f <= 1'b0; tx_f <= 1'b0; rs_f <= 1'b0;
      hit_a <= 1'b0; hit_b <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en      <= reg_wdata[CB_EN];
        ack_lvl <= reg_wdata[CB_ACKL];
      end
      if (wr_owna) own_a <= reg_wdata[DW-1:1];
      if (wr_ownb) own_b <= reg_wdata[DW-1:1];
      if (ev_rx)        data_q <= rx_byte;
      else if (wr_data) data_q <= reg_wdata;
      if (ev_rx)                            rx_f <= 1'b1;
      else if (wr_stat && reg_wdata[SB_RXF]) rx_f <= 1'b0;
      if (ev_tx)                            tx_f <= 1'b1;
      else if (wr_stat && reg_wdata[SB_TXF]) tx_f <= 1'b0;
      if (ev_rs)                            rs_f <= 1'b1;
      else if (wr_stat && reg_wdata[SB_RSF]) rs_f <= 1'b0;
      if (ev_addr) begin
        hit_a <= hit_a_i;
        hit_b <= hit_b_i;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[SB_RXF]  = rx_f;
    status[SB_TXF]  = tx_f;
    status[SB_HITA] = hit_a;
    status[SB_HITB] = hit_b;
    status[SB_DIR]  = dir;
    status[SB_RACK] = rx_ack;
    status[SB_BUSY] = busy;
    status[SB_RSF]  = rs_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        AW'(OFS_CTRL): reg_rdata <= {en, {(DW-2){1'b0}}, ack_lvl};
        AW'(OFS_STAT): reg_rdata <= status;
        AW'(OFS_OWNA): reg_rdata <= {own_a, 1'b0};
        AW'(OFS_OWNB): reg_rdata <= {own_b, 1'b0};
        AW'(OFS_DATA): reg_rdata <= data_q;
        default:       reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave #(
  parameter int            DW       = 8,
  parameter int            AW       = 3,
  parameter int            STAGES   = 2,
  parameter logic [DW-1:0] OWNA_RST = 8'hA0,
  parameter logic [DW-1:0] OWNB_RST = 8'h60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rx_irq,
  output logic          tx_irq,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe
);
  logic          sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic          ctl_en, ack_lvl;
  logic [DW-2:0] own_a, own_b;
  logic [DW-1:0] data_q, rx_byte, status;
  logic          eng_busy, eng_dir, eng_rack, ev_addr, e_hit_a, e_hit_b;
  logic          ev_rx, ev_tx, ev_rs, eng_ign;
  logic          hit_a_flag, rs_flag;

  i2cs_front #(.STAGES(STAGES)) u_front (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  i2cs_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .en(ctl_en), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .own_a(own_a), .own_b(own_b), .ack_lvl(ack_lvl), .tx_byte(data_q),
    .sda_oe(sda_oe), .busy(eng_busy), .dir(eng_dir), .rx_ack(eng_rack),
    .ev_addr(ev_addr), .hit_a(e_hit_a), .hit_b(e_hit_b), .ev_rx(ev_rx),
    .rx_byte(rx_byte), .ev_tx(ev_tx), .ev_rs(ev_rs), .ign(eng_ign)
  );

  i2cs_regs #(.DW(DW), .AW(AW), .OWNA_RST(OWNA_RST), .OWNB_RST(OWNB_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_rx(ev_rx), .rx_byte(rx_byte), .ev_tx(ev_tx), .ev_addr(ev_addr),
    .hit_a_i(e_hit_a), .hit_b_i(e_hit_b), .ev_rs(ev_rs), .dir(eng_dir),
    .rx_ack(eng_rack), .busy(eng_busy), .en(ctl_en), .ack_lvl(ack_lvl),
    .own_a(own_a), .own_b(own_b), .data_q(data_q), .rx_f(rx_irq),
    .tx_f(tx_irq), .hit_a(hit_a_flag), .rs_f(rs_flag), .status(status)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic en,
  input logic busy,
  input logic stop_p,
  input logic hit_a_flag,
  input logic rs_flag,
  input logic ign
);
  // R11
  sda_low_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sda_oe && !busy));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_p && en) |=> !busy);

  // R3
  hit_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_a_flag) |-> busy);

  // R4
  ignore_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ign && $past(ign)) |-> !sda_oe);

  // R8
  restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_flag) |-> busy);
endmodule

bind i2c_dual_slave i2cs_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .en(ctl_en),
  .busy(eng_busy), .stop_p(stop_p), .hit_a_flag(hit_a_flag),
  .rs_flag(rs_flag), .ign(eng_ign)
);

// File: tb/i2c_dual_slave_bench.sv
`timescale 1ns/1ps
module i2c_dual_slave_bench;
  localparam int Q  = 20;
  localparam int WD = 195000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rx_irq, tx_irq;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_line;
  logic       sda_oe;

  int checks = 0;
  int fails  = 0;
  int r11_bad = 0;
  int cyc = 0;
  logic oe_prev = 1'b0;

  assign sda_line = ~(m_low | sda_oe);

  always #5 clk = ~clk;

  i2c_dual_slave u_i2c_dual_slave (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R11 monitor: SDA drive never changes while SCL is high
  always @(posedge clk) begin
    #1;
    if (!rst && scl && (sda_oe !== oe_prev)) r11_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic bus_start();
    m_low = 1'b0; waitq(Q);
    scl = 1'b1;   waitq(Q);
    m_low = 1'b1; waitq(Q);
    scl = 1'b0;   waitq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; waitq(Q);
    scl = 1'b1;   waitq(Q);
    m_low = 1'b0; waitq(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; waitq(Q);
    scl = 1'b1; waitq(2*Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; waitq(Q);
    scl = 1'b1;   waitq(Q);
    b = sda_line; waitq(Q);
    scl = 1'b0;   waitq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       ack;
    logic       ha, hb;
    waitq(4);
    rst = 1'b0;
    waitq(4);

    // R1 reset values
    rd(3'd0, v); check("R1 ctrl", v, 8'h00);
    rd(3'd1, v); check("R1 status", v, 8'h00);
    rd(3'd2, v); check("R1 own addr A", v, 8'hA0);
    rd(3'd3, v); check("R1 own addr B", v, 8'h60);
    rd(3'd4, v); check("R1 data", v, 8'h00);
    check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);

    wr(3'd0, 8'h80);

    // R3 R4 R2 sweep of every 7-bit address, write direction
    for (int a = 0; a < 128; a++) begin
      ha = (a == 'h50);
      hb = (a == 'h30);
      bus_start();
      put_byte({a[6:0], 1'b0}, ack);
      check($sformatf("R3/R4 ack addr 0x%02h", a), {7'd0, ack}, {7'd0, ~(ha | hb)});
      rd(3'd1, v);
      check($sformatf("R3/R2 status busy addr 0x%02h", a), v, {2'b00, ha, hb, 4'b0010});
      bus_stop();
      rd(3'd1, v);
      check($sformatf("R2 status after stop addr 0x%02h", a), v, {2'b00, ha, hb, 4'b0000});
    end

    // R4 data after mismatched address is ignored
    bus_start();
    put_byte(8'hA2, ack);
    check("R4 no ack on 0x51", {7'd0, ack}, 8'h01);
    put_byte(8'hFF, ack);
    check("R4 no ack on data", {7'd0, ack}, 8'h01);
    bus_stop();
    rd(3'd4, v); check("R4 data untouched", v, 8'h00);
    check("R4 rx_irq clear", {7'd0, rx_irq}, 8'h00);

    // R6 write transfer, R9 write-one-to-clear
    bus_start();
    put_byte(8'hA0, ack);
    check("R3 ack addr A", {7'd0, ack}, 8'h00);
    put_byte(8'hA5, ack);
    check("R6 ack level 0", {7'd0, ack}, 8'h00);
    rd(3'd4, v); check("R6 data received", v, 8'hA5);
    check("R6 rx_irq", {7'd0, rx_irq}, 8'h01);
    rd(3'd1, v); check("R6 status", v, 8'hA2);
    wr(3'd1, 8'h00);
    rd(3'd1, v); check("R9 write zero keeps", v, 8'hA2);
    wr(3'd1, 8'h80);
    rd(3'd1, v); check("R9 write one clears", v, 8'h22);
    wr(3'd0, 8'h81);
    put_byte(8'h3C, ack);
    check("R6 ack level 1", {7'd0, ack}, 8'h01);
    rd(3'd4, v); check("R6 second byte", v, 8'h3C);
    bus_stop();
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h80);

    // R5 R7 read transfer
    wr(3'd4, 8'hC3);
    bus_start();
    put_byte(8'h61, ack);
    check("R3 ack addr B read", {7'd0, ack}, 8'h00);
    rd(3'd1, v); check("R5 dir read", v, 8'h1A);
    get_byte(v); check("R7 first byte", v, 8'hC3);
    check("R7 tx_irq", {7'd0, tx_irq}, 8'h01);
    wr(3'd4, 8'h5A);
    wr(3'd1, 8'h40);
    put_bit(1'b0);
    rd(3'd1, v); check("R7 master ack held", v, 8'h1A);
    get_byte(v); check("R7 next byte", v, 8'h5A);
    put_bit(1'b1);
    rd(3'd1, v); check("R7 master nack held", v, 8'h5E);
    bus_stop();
    wr(3'd1, 8'h40);

    // R8 repeated start
    bus_start();
    put_byte(8'hA0, ack);
    put_byte(8'h11, ack);
    check("R6 ack before restart", {7'd0, ack}, 8'h00);
    bus_start();
    put_byte(8'h61, ack);
    check("R8 ack after restart", {7'd0, ack}, 8'h00);
    rd(3'd1, v); check("R8 restart status", v, 8'h9F);
    get_byte(v); check("R7 byte after restart", v, 8'h11);
    put_bit(1'b1);
    bus_stop();
    wr(3'd1, 8'hC1);
    rd(3'd1, v); check("R9 flags cleared", v, 8'h1C);

    // R10 disabled block
    wr(3'd0, 8'h00);
    bus_start();
    put_byte(8'hA0, ack);
    check("R10 no ack when off", {7'd0, ack}, 8'h01);
    rd(3'd1, v); check("R10 busy stays 0", v, 8'h1C);
    bus_stop();

    // R11
    check("R11 sda changes with scl high", r11_bad[7:0], 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule